// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Reload Baud Generator

This block takes in asynchronous serial frames on a single input line and delivers each byte to a holding buffer. A reload counter loaded with a divisor `n` sets the timing. It divides a prescaled system clock by `n+1` to make a sixteen-times oversampling tick, and sixteen of those ticks make one bit period. The prescaler passes the system clock through unchanged or divides it by 8 or by 32. For example, a 16 MHz clock with no prescale and `n = 103` gives 16e6 / (104·16) ≈ 9615 bit/s, which is the usual 9600 setting.

A falling edge on the line starts a frame. The start bit is confirmed at its middle, and then the data bits (least significant first), an optional parity bit and one or two stop bits are each sampled at mid-bit. When the frame ends, the byte and its error status go into the buffer. A ready flag and a sticky interrupt request are raised at that point, and an overrun is flagged if the previous byte was never read. A read strobe clears the ready flag, and an acknowledge strobe clears the interrupt request. When flow control is turned on and the shared pin is set to request-to-send, an RTS output holds the sender off. It does this while a frame is in progress and while an unread byte sits in the buffer.

Top module: `serial_rx_unit`

## Requirements
- R1: The bit period is P·(n+1)·16 system clocks. `n` is the `divisor` input. P comes from `clk_sel`: 0 gives 1, 1 gives 8, and 2 or 3 gives 32.
- R2: A frame starts only on a high-to-low transition of `rxd`. If the line reads high at the middle of the start bit, the attempt is dropped, no flag changes, and the receiver goes back to waiting.
- R3: Eight data bits are taken least significant bit first, each sampled at mid-bit. The assembled byte appears on `rx_data` when the frame completes.
- R4: When `par_en` is 1, a parity bit follows the data. With `par_odd` = 0, the data bits plus the parity bit must hold an even number of ones. With `par_odd` = 1, they must hold an odd number. A mismatch sets `err_parity` for that byte. With `par_en` = 0, `err_parity` is 0.
- R5: `two_stop` = 1 expects two stop bits, and 0 expects one. If any expected stop bit is sampled low, `err_frame` is set for that byte, and the byte is still delivered.
- R6: Completing a frame sets `rx_ready`. A one-cycle pulse on `rd_strobe` clears it.
- R7: If a frame completes while `rx_ready` is still set and there is no read in the same cycle, `err_overrun` is set. It stays set until `rd_strobe` clears it, and the new byte replaces the old one.
- R8: Completing a frame sets `irq_req`. Only `irq_ack` clears it; `rd_strobe` leaves it unchanged.
- R9: `rts` is 0 unless `fc_en` = 1 and `fc_rts_sel` = 1. When both are 1, `rts` is 1 while reception is disabled, from start detection until the frame completes, and while `rx_ready` is set. Otherwise it is 0.
- R10: While `rx_en` is 0, frames on `rxd` are ignored. The buffer and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Prescale select: 0 gives /1, 1 gives /8, 2 or 3 gives /32 |
| divisor | input | DIV_W | Reload value n; the counter divides by n+1 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| rx_en | input | 1 | Receive enable |
| fc_en | input | 1 | Flow control enable |
| fc_rts_sel | input | 1 | Shared pin works as RTS when 1 |
| rxd | input | 1 | Serial input, idles high |
| rd_strobe | input | 1 | Buffer read pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| rx_data | output | DATA_BITS | Receive buffer |
| rx_ready | output | 1 | Byte waiting in buffer |
| err_parity | output | 1 | Parity error of buffered byte |
| err_frame | output | 1 | Stop-bit error of buffered byte |
| err_overrun | output | 1 | Unread byte was overwritten |
| irq_req | output | 1 | Sticky receive interrupt request |
| rts | output | 1 | 1 asks the sender to pause |

## Verification
The bench sends all 256 byte values at the fastest rate and cycles through the four frame formats as it goes. If the shift direction or a sample point were wrong, bytes would come out bit-reversed or shifted. Wrong parity sense or stop-bit counting would show up as false errors on these clean frames. Separate runs at each prescale choice with nonzero divisors catch a counter that divides by n instead of n+1; in that case every bit would drift and the data would be wrong.

A short low pulse checks that the start bit is confirmed at mid-bit. A design without that check would deliver a bogus byte. Further cases use corrupted parity and stop bits, back-to-back frames with no read in between, a read given without an acknowledge, disabled reception, and both settings of the RTS select. These catch errors that are not latched, an overrun that never sets or never clears, an interrupt wrongly cleared by a read, and an RTS that drives the pin when it should not.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP1 = 3'd4,
      S_STOP2 = 3'd5
   } srx_state_e;

   typedef struct packed {
      logic perr;
      logic ferr;
   } srx_status_t;

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
   parameter int DIV_W        = 8,
   parameter int PRESCALE_MID = 8,
   parameter int PRESCALE_HI  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       sel,
   input  logic [DIV_W-1:0] divisor,
   output logic             os_tick
);

   localparam int PW = $clog2(PRESCALE_HI);

   generate
      if (PRESCALE_MID < 2 || PRESCALE_HI <= PRESCALE_MID) begin : g_bad_pre
         $error("srx_baud: prescale ratios must satisfy 2 <= MID < HI");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("srx_baud: DIV_W must be positive");
      end
   endgenerate

   logic [PW-1:0]    pre_cnt;
   logic [PW-1:0]    pre_lim;
   logic             pre_tick;
   logic [DIV_W-1:0] div_cnt;

   always_comb begin
      case (sel)
         2'd0:    pre_lim = '0;
         2'd1:    pre_lim = PW'(PRESCALE_MID - 1);
         default: pre_lim = PW'(PRESCALE_HI - 1);
      endcase
   end

   assign pre_tick = run && (pre_cnt >= pre_lim);
   assign os_tick  = pre_tick && (div_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (!run || pre_tick) begin
         pre_cnt <= '0;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (!run) begin
         div_cnt <= divisor;
      end else if (pre_tick) begin
         div_cnt <= (div_cnt == '0) ? divisor : div_cnt - 1'b1;
      end
   end

   // R1: a nonzero divisor forbids two oversampling ticks in a row
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (os_tick && divisor != '0) |=> !os_tick);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OS        = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 rx_s,
   input  logic                 os_tick,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 two_stop,
   output logic                 busy,
   output logic                 done,
   output logic [DATA_BITS-1:0] data,
   output srx_status_t          status
);

   localparam int OW  = $clog2(OS);
   localparam int IW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam int MID = OS / 2 - 1;

   generate
      if (OS < 4 || (OS & (OS - 1)) != 0) begin : g_bad_os
         $error("srx_frame: OS must be a power of two of at least 4");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("srx_frame: DATA_BITS must lie in 5..9");
      end
   endgenerate

   srx_state_e           state;
   logic [OW-1:0]        os_cnt;
   logic [IW-1:0]        bit_idx;
   logic [DATA_BITS-1:0] shreg;
   logic                 par_acc;
   logic                 rx_prev;
   logic                 bit_end;

   assign bit_end = os_tick && (os_cnt == OW'(OS - 1));
   assign busy    = (state != S_IDLE);
   assign data    = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         os_cnt  <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         rx_prev <= 1'b1;
         done    <= 1'b0;
         status  <= '0;
      end else begin
         done    <= 1'b0;
         rx_prev <= rx_s;
         if (!en) begin
            state  <= S_IDLE;
            os_cnt <= '0;
         end else begin
            if (os_tick && state != S_IDLE) begin
               os_cnt <= os_cnt + 1'b1;
            end
            case (state)
               S_IDLE: begin
                  if (rx_prev && !rx_s) begin
                     state  <= S_START;
                     os_cnt <= '0;
                  end
               end
               S_START: begin
                  if (os_tick && os_cnt == OW'(MID)) begin
                     os_cnt <= '0;
                     if (rx_s) begin
                        state <= S_IDLE;
                     end else begin
                        state   <= S_DATA;
                        bit_idx <= '0;
                        par_acc <= 1'b0;
                        status  <= '0;
                     end
                  end
               end
               S_DATA: begin
                  if (bit_end) begin
                     shreg   <= {rx_s, shreg[DATA_BITS-1:1]};
                     par_acc <= par_acc ^ rx_s;
                     if (bit_idx == IW'(DATA_BITS - 1)) begin
                        state <= par_en ? S_PAR : S_STOP1;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
               S_PAR: begin
                  if (bit_end) begin
                     status.perr <= par_acc ^ rx_s ^ par_odd;
                     state       <= S_STOP1;
                  end
               end
               S_STOP1: begin
                  if (bit_end) begin
                     status.ferr <= !rx_s;
                     if (two_stop) begin
                        state <= S_STOP2;
                     end else begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                     end
                  end
               end
               S_STOP2: begin
                  if (bit_end) begin
                     status.ferr <= status.ferr | !rx_s;
                     state       <= S_IDLE;
                     done        <= 1'b1;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R2: a start bit reading high at its middle abandons the frame
   a_r2_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == S_START && os_tick && os_cnt == OW'(MID) && rx_s)
      |=> (state == S_IDLE && !done));

   // R10: disabling reception parks the receiver
   a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == S_IDLE));

   // R5: a completion pulse only follows a stop-bit state
   a_r5_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(state) == S_STOP1 || $past(state) == S_STOP2));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import srx_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter int DATA_BITS    = 8,
   parameter int OS           = 16,
   parameter int PRESCALE_MID = 8,
   parameter int PRESCALE_HI  = 32,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_FLOW     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           clk_sel,
   input  logic [DIV_W-1:0]     divisor,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 two_stop,
   input  logic                 rx_en,
   input  logic                 fc_en,
   input  logic                 fc_rts_sel,
   input  logic                 rxd,
   input  logic                 rd_strobe,
   input  logic                 irq_ack,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 err_parity,
   output logic                 err_frame,
   output logic                 err_overrun,
   output logic                 irq_req,
   output logic                 rts
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_rx_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   os_tick;
   logic                   fr_busy;
   logic                   fr_done;
   logic [DATA_BITS-1:0]   fr_data;
   srx_status_t            fr_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   srx_baud #(
      .DIV_W        (DIV_W),
      .PRESCALE_MID (PRESCALE_MID),
      .PRESCALE_HI  (PRESCALE_HI)
   ) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (rx_en),
      .sel     (clk_sel),
      .divisor (divisor),
      .os_tick (os_tick)
   );

   srx_frame #(
      .DATA_BITS (DATA_BITS),
      .OS        (OS)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .rx_s     (rx_s),
      .os_tick  (os_tick),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .busy     (fr_busy),
      .done     (fr_done),
      .data     (fr_data),
      .status   (fr_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         rx_ready    <= 1'b0;
         err_overrun <= 1'b0;
         irq_req     <= 1'b0;
      end else begin
         if (fr_done) begin
            rx_data    <= fr_data;
            err_parity <= fr_status.perr;
            err_frame  <= fr_status.ferr;
         end
         if (fr_done) begin
            rx_ready <= 1'b1;
         end else if (rd_strobe) begin
            rx_ready <= 1'b0;
         end
         if (fr_done && rx_ready && !rd_strobe) begin
            err_overrun <= 1'b1;
         end else if (rd_strobe) begin
            err_overrun <= 1'b0;
         end
         if (fr_done) begin
            irq_req <= 1'b1;
         end else if (irq_ack) begin
            irq_req <= 1'b0;
         end
      end
   end

   generate
      if (HAS_FLOW) begin : g_flow
         assign rts = fc_en && fc_rts_sel && (!rx_en || fr_busy || rx_ready);
      end else begin : g_no_flow
         assign rts = 1'b0;
      end
   endgenerate

   // R6: a completed frame leaves a byte flagged ready
   a_r6_ready_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done |=> rx_ready);

   // R7: loading over an unread byte raises overrun
   a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && rx_ready && !rd_strobe) |=> err_overrun);

   // R8: load raises the request; a read alone never drops it
   a_r8_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done |=> irq_req);
   a_r8_read_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && rd_strobe && !irq_ack) |=> irq_req);

   // R9: the flow pin stays low unless enabled and routed as RTS
   a_r9_rts_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(fc_en && fc_rts_sel) |-> !rts);

endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] clk_sel;
   logic [7:0] divisor;
   logic       par_en, par_odd, two_stop, rx_en, fc_en, fc_rts_sel;
   logic       rxd, rd_strobe, irq_ack;
   logic [7:0] rx_data;
   logic       rx_ready, err_parity, err_frame, err_overrun, irq_req, rts;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   serial_rx_unit u_serial_rx_unit (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .divisor(divisor),
      .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
      .rx_en(rx_en), .fc_en(fc_en), .fc_rts_sel(fc_rts_sel), .rxd(rxd),
      .rd_strobe(rd_strobe), .irq_ack(irq_ack), .rx_data(rx_data),
      .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .irq_req(irq_req), .rts(rts)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 200000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bit_clocks(input int sel, input int n);
      int p = (sel == 0) ? 1 : (sel == 1) ? 8 : 32;
      return p * (n + 1) * 16;
   endfunction

   task automatic hold(input logic v, input int bc);
      rxd = v;
      repeat (bc) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int bc, input logic bad_par,
                       input logic bad_s1, input logic bad_s2);
      logic p;
      p = (^d) ^ par_odd ^ bad_par;
      hold(1'b0, bc);
      for (int i = 0; i < 8; i++) hold(d[i], bc);
      if (par_en) hold(p, bc);
      hold(!bad_s1, bc);
      if (two_stop) hold(!bad_s2, bc);
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_rd();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      int bc;
      rst_n = 1'b0; clk_sel = 2'd0; divisor = 8'd0;
      par_en = 0; par_odd = 0; two_stop = 0; rx_en = 0;
      fc_en = 0; fc_rts_sel = 0; rxd = 1; rd_strobe = 0; irq_ack = 0;
      repeat (5) @(negedge clk);
      chk("R6 reset ready", rx_ready, 0);
      chk("R8 reset irq", irq_req, 0);
      chk("R7 reset overrun", err_overrun, 0);
      chk("R9 reset rts", rts, 0);
      rst_n = 1'b1;
      fc_en = 1; fc_rts_sel = 1;
      @(negedge clk);
      chk("R9 rts while disabled", rts, 1);
      rx_en = 1;
      repeat (4) @(negedge clk);
      chk("R9 rts idle empty", rts, 0);

      // R3 R4 R5: full byte sweep at the fastest rate, rotating formats
      bc = bit_clocks(0, 0);
      for (int v = 0; v < 256; v++) begin
         par_en   = (v % 4 == 1) || (v % 4 == 2);
         par_odd  = (v % 4 == 2);
         two_stop = (v % 4 == 3);
         send(v[7:0], bc, 0, 0, 0);
         chk("R3 sweep data", rx_data, v);
         chk("R6 sweep ready", rx_ready, 1);
         chk("R4 sweep parity clean", err_parity, 0);
         chk("R5 sweep stop clean", err_frame, 0);
         pulse_rd();
         chk("R6 ready cleared by read", rx_ready, 0);
      end
      pulse_ack();

      // R4: corrupted parity, both senses
      par_en = 1; par_odd = 0; two_stop = 0;
      send(8'h96, bc, 1, 0, 0);
      chk("R4 even parity error", err_parity, 1);
      chk("R4 data despite parity", rx_data, 8'h96);
      pulse_rd();
      par_odd = 1;
      send(8'h3B, bc, 1, 0, 0);
      chk("R4 odd parity error", err_parity, 1);
      pulse_rd();
      par_en = 0;
      send(8'h3B, bc, 0, 0, 0);
      chk("R4 parity off clears", err_parity, 0);
      pulse_rd();

      // R5: bad first stop, bad second stop
      send(8'h5E, bc, 0, 1, 0);
      chk("R5 stop low framing", err_frame, 1);
      chk("R5 byte still delivered", rx_data, 8'h5E);
      chk("R5 ready after framing", rx_ready, 1);
      pulse_rd();
      two_stop = 1;
      send(8'h21, bc, 0, 0, 1);
      chk("R5 second stop low", err_frame, 1);
      pulse_rd();
      two_stop = 0;

      // R1: rate selections with nonzero divisors
      clk_sel = 2'd0; divisor = 8'd5;
      send(8'h5A, bit_clocks(0, 5), 0, 0, 0);
      chk("R1 rate /1 n=5", rx_data, 8'h5A);
      pulse_rd();
      clk_sel = 2'd1; divisor = 8'd2;
      send(8'hA5, bit_clocks(1, 2), 0, 0, 0);
      chk("R1 rate /8 n=2", rx_data, 8'hA5);
      pulse_rd();
      clk_sel = 2'd2; divisor = 8'd0;
      send(8'h3C, bit_clocks(2, 0), 0, 0, 0);
      chk("R1 rate /32 n=0", rx_data, 8'h3C);
      pulse_rd();
      clk_sel = 2'd3; divisor = 8'd1;
      send(8'h81, bit_clocks(3, 1), 0, 0, 0);
      chk("R1 rate sel3 n=1", rx_data, 8'h81);
      chk("R1 rate clean frame", err_frame, 0);
      pulse_rd();
      clk_sel = 2'd0; divisor = 8'd0;
      pulse_ack();

      // R2: short low pulse is rejected, then a real frame is accepted
      rxd = 0;
      repeat (3) @(negedge clk);
      rxd = 1;
      repeat (40) @(negedge clk);
      chk("R2 glitch no ready", rx_ready, 0);
      chk("R2 glitch no irq", irq_req, 0);
      chk("R2 glitch rts released", rts, 0);
      send(8'hC3, bc, 0, 0, 0);
      chk("R2 frame after glitch", rx_data, 8'hC3);
      pulse_rd();

      // R9: rts high mid-frame and while buffer full
      fork
         send(8'h4D, bc, 0, 0, 0);
         begin
            repeat (bc * 4) @(negedge clk);
            chk("R9 rts mid frame", rts, 1);
         end
      join
      chk("R9 rts buffer full", rts, 1);
      pulse_rd();
      chk("R9 rts after read", rts, 0);
      fc_rts_sel = 0;
      fork
         send(8'h4E, bc, 0, 0, 0);
         begin
            repeat (bc * 4) @(negedge clk);
            chk("R9 rts off when CTS routed", rts, 0);
         end
      join
      pulse_rd();
      fc_rts_sel = 1;

      // R8: read keeps request; acknowledge drops it
      chk("R8 irq set by load", irq_req, 1);
      pulse_ack();
      chk("R8 ack clears irq", irq_req, 0);
      send(8'h11, bc, 0, 0, 0);
      pulse_rd();
      chk("R8 read keeps irq", irq_req, 1);
      pulse_ack();

      // R7: overrun on unread buffer
      send(8'hAA, bc, 0, 0, 0);
      chk("R7 no overrun first", err_overrun, 0);
      send(8'h55, bc, 0, 0, 0);
      chk("R7 overrun set", err_overrun, 1);
      chk("R7 newer byte kept", rx_data, 8'h55);
      pulse_rd();
      chk("R7 overrun cleared", err_overrun, 0);
      chk("R7 ready cleared", rx_ready, 0);
      pulse_ack();

      // R10: disabled receiver ignores a frame
      rx_en = 0;
      repeat (2) @(negedge clk);
      chk("R9 rts receiver off", rts, 1);
      send(8'h77, bc, 0, 0, 0);
      chk("R10 no ready when off", rx_ready, 0);
      chk("R10 buffer kept", rx_data, 8'h55);
      chk("R10 no irq when off", irq_req, 0);
      rx_en = 1;
      repeat (4) @(negedge clk);
      send(8'hE7, bc, 0, 0, 0);
      chk("R10 works after re-enable", rx_data, 8'hE7);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule